// File: doc/BRIEF.md
# Tick-Driven Elapsed Time and Interval Alarm

This block keeps wall-clock style elapsed time from a strobe that arrives 128 times per second. The count is held in four byte registers: fractional ticks, seconds, minutes and hours. Hours can wrap either at the end of a day or at the full byte range. Beside this chain sits an interval alarm. An interval counter advances on every rollover of a chosen unit (tick, second, minute or hour). When it reaches a programmed interval it raises a sticky interrupt flag. It then either starts the next interval or disables itself.

Software reaches every register through a byte-wide write port and a combinational read port, both addressed by a 3-bit select. The elapsed counters can be preloaded at any time. The alarm is armed, disarmed and configured through one control byte. That byte also carries the interrupt flag, so software reads the flag there and clears it by writing 0.

Register selects are: 0 control, 1 interval, 2 fraction, 3 seconds, 4 minutes, 5 hours, 6 interval count (read only), 7 reads 0. Control bits are: [0] run, [1] alarm enable, [2] one-shot, [4:3] unit (0 tick, 1 second, 2 minute, 3 hour), [5] day-wrap hours, [6] interrupt flag, [7] reads 0.

Top module: `tick_interval_timer`

## Requirements
- R1: After reset every readable register (selects 0 to 6) reads 00h and `irq` is low.
- R2: While run (control bit 0) is 1, each cycle with `tick` high advances the fraction count. A fraction at or above 127 becomes 0 on a tick and carries into seconds.
- R3: A seconds or minutes value at or above 59 that receives a carry becomes 0 and carries into the next unit. Otherwise a carry adds 1.
- R4: With control bit 5 set, hours at or above 23 wrap to 0 on a carry. With bit 5 clear, hours wrap from 255 to 0.
- R5: While run is 0, ticks leave fraction, seconds, minutes, hours and the interval count unchanged.
- R6: While the alarm is enabled (bit 1), the interval count advances once per event of the unit chosen by bits [4:3]. Unit 0 is each counted tick; units 1, 2 and 3 are the carries out of fraction, seconds and minutes.
- R7: When an advance would make the interval count equal to the interval register, the count returns to 0 instead, the flag (bit 6) sets and `irq` goes high. With one-shot clear, counting then continues.
- R8: With one-shot (bit 2) set, a match also clears the alarm enable, so no further matches occur.
- R9: A control write with bit 1 equal to 0 clears the interval count and stops it.
- R10: The flag stays set until a control write puts 0 in bit 6. If a match falls in the same cycle as that write, the flag is set.
- R11: A write to a count register loads the written value, and the load takes priority over a tick or carry to that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe, 128 per second |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interval interrupt, equal to the sticky flag |

## Verification
Two things can land on the same clock edge: the alarm's hardware match, which sets the flag, and a software control write that clears the flag. The bench counts enabled ticks so that a flag-clearing control write falls exactly on the matching tick, and it expects the flag to read 1 afterwards. A second collision is a register preload that coincides with a tick or an incoming carry. A long random phase mixes ticks with writes to every register, including out-of-range counts. A behavioural model is compared against every register after every cycle.

// File: rtl/tic_pkg.sv
package tic_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL = 3'd0,
      SEL_IVAL = 3'd1,
      SEL_FRAC = 3'd2,
      SEL_SEC  = 3'd3,
      SEL_MIN  = 3'd4,
      SEL_HOUR = 3'd5,
      SEL_ICNT = 3'd6
   } tic_sel_e;

   typedef enum logic [1:0] {
      UNIT_TICK = 2'd0,
      UNIT_SEC  = 2'd1,
      UNIT_MIN  = 2'd2,
      UNIT_HOUR = 2'd3
   } tic_unit_e;

   localparam int CB_RUN  = 0;
   localparam int CB_IEN  = 1;
   localparam int CB_ONE  = 2;
   localparam int CB_UNIT = 3;
   localparam int CB_H24  = 5;
   localparam int CB_FLAG = 6;
   localparam int CTRL_BITS = 7;
endpackage

// File: rtl/tic_digit.sv
module tic_digit #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic [W-1:0] last,
   output logic [W-1:0] q,
   output logic         carry
);
   assign carry = inc && (q >= last);

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (ld)
         q <= ld_val;
      else if (inc)
         q <= carry ? '0 : q + 1'b1;
   end
endmodule

// File: rtl/tic_chain.sv
module tic_chain #(
   parameter int W      = 8,
   parameter int FRAC_N = 128,
   parameter int SEC_N  = 60,
   parameter int MIN_N  = 60,
   parameter int HR24_N = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              hour24,
   input  logic [3:0]        ld,
   input  logic [W-1:0]      ld_val,
   output logic [3:0][W-1:0] cnt,
   output logic [3:0]        carry
);
   localparam int STAGES = 4;
   localparam logic [W-1:0] FRAC_LAST = W'(FRAC_N - 1);
   localparam logic [W-1:0] SEC_LAST  = W'(SEC_N - 1);
   localparam logic [W-1:0] MIN_LAST  = W'(MIN_N - 1);
   localparam logic [W-1:0] H24_LAST  = W'(HR24_N - 1);
   localparam logic [W-1:0] HFULL     = {W{1'b1}};

   logic [STAGES-1:0]        inc_v;
   logic [STAGES-1:0][W-1:0] last_v;

   assign inc_v = {carry[STAGES-2:0], adv};

   always_comb begin
      last_v[0] = FRAC_LAST;
      last_v[1] = SEC_LAST;
      last_v[2] = MIN_LAST;
      last_v[3] = hour24 ? H24_LAST : HFULL;
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      tic_digit #(.W(W)) u_digit (
         .clk    (clk),
         .rst_n  (rst_n),
         .inc    (inc_v[i]),
         .ld     (ld[i]),
         .ld_val (ld_val),
         .last   (last_v[i]),
         .q      (cnt[i]),
         .carry  (carry[i])
      );
   end
endmodule

// File: rtl/tic_interval.sv
module tic_interval #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ev,
   input  logic         ien,
   input  logic [W-1:0] ival,
   input  logic         clr,
   output logic [W-1:0] icnt,
   output logic         match
);
   logic [W-1:0] nxt;

   assign nxt   = icnt + 1'b1;
   assign match = ien && ev && (nxt == ival);

   always_ff @(posedge clk) begin
      if (!rst_n)
         icnt <= '0;
      else if (clr || match)
         icnt <= '0;
      else if (ien && ev)
         icnt <= nxt;
   end
endmodule

// File: rtl/tick_interval_timer.sv
module tick_interval_timer
   import tic_pkg::*;
#(
   parameter int CNT_W  = 8,
   parameter int FRAC_N = 128,
   parameter int SEC_N  = 60,
   parameter int MIN_N  = 60,
   parameter int HR24_N = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             wr_en,
   input  logic [2:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [2:0]       rd_sel,
   output logic [CNT_W-1:0] rd_data,
   output logic             irq
);
   localparam int UNITS = 4;

   if (CNT_W < CTRL_BITS) begin : g_bad_width
      $error("CNT_W too narrow for the control byte");
   end
   if (FRAC_N < 2 || FRAC_N > 2**CNT_W) begin : g_bad_frac
      $error("FRAC_N out of range");
   end
   if (SEC_N < 2 || SEC_N > 2**CNT_W || MIN_N < 2 || MIN_N > 2**CNT_W) begin : g_bad_sm
      $error("SEC_N or MIN_N out of range");
   end
   if (HR24_N < 2 || HR24_N > 2**CNT_W) begin : g_bad_hour
      $error("HR24_N out of range");
   end

   logic             run_q, ien_q, one_q, h24_q, flag_q;
   logic [1:0]       unit_q;
   logic [CNT_W-1:0] ival_q;

   logic             ctrl_wr, ival_wr, clr_icnt, adv, ev, match;
   logic [3:0]       ld;
   logic [3:0][CNT_W-1:0] cnt;
   logic [3:0]       carry;
   logic [UNITS-1:0] unit_ev;
   logic [CNT_W-1:0] icnt;
   logic [CNT_W-1:0] ctrl_rd;

   assign ctrl_wr  = wr_en && (wr_sel == SEL_CTRL);
   assign ival_wr  = wr_en && (wr_sel == SEL_IVAL);
   assign ld[0]    = wr_en && (wr_sel == SEL_FRAC);
   assign ld[1]    = wr_en && (wr_sel == SEL_SEC);
   assign ld[2]    = wr_en && (wr_sel == SEL_MIN);
   assign ld[3]    = wr_en && (wr_sel == SEL_HOUR);
   assign clr_icnt = ctrl_wr && !wr_data[CB_IEN];
   assign adv      = tick && run_q;

   tic_chain #(
      .W(CNT_W), .FRAC_N(FRAC_N), .SEC_N(SEC_N), .MIN_N(MIN_N), .HR24_N(HR24_N)
   ) u_chain (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .hour24 (h24_q),
      .ld     (ld),
      .ld_val (wr_data),
      .cnt    (cnt),
      .carry  (carry)
   );

   assign unit_ev = {carry[2:0], adv};
   assign ev      = unit_ev[unit_q];

   tic_interval #(.W(CNT_W)) u_alarm (
      .clk   (clk),
      .rst_n (rst_n),
      .ev    (ev),
      .ien   (ien_q),
      .ival  (ival_q),
      .clr   (clr_icnt),
      .icnt  (icnt),
      .match (match)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         ien_q  <= 1'b0;
         one_q  <= 1'b0;
         h24_q  <= 1'b0;
         flag_q <= 1'b0;
         unit_q <= UNIT_TICK;
      end else begin
         if (ctrl_wr) begin
            run_q  <= wr_data[CB_RUN];
            ien_q  <= wr_data[CB_IEN];
            one_q  <= wr_data[CB_ONE];
            unit_q <= wr_data[CB_UNIT +: 2];
            h24_q  <= wr_data[CB_H24];
            flag_q <= wr_data[CB_FLAG];
         end
         if (match) begin
            flag_q <= 1'b1;
            if (one_q)
               ien_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ival_q <= '0;
      else if (ival_wr)
         ival_q <= wr_data;
   end

   always_comb begin
      ctrl_rd              = '0;
      ctrl_rd[CB_RUN]      = run_q;
      ctrl_rd[CB_IEN]      = ien_q;
      ctrl_rd[CB_ONE]      = one_q;
      ctrl_rd[CB_UNIT +: 2] = unit_q;
      ctrl_rd[CB_H24]      = h24_q;
      ctrl_rd[CB_FLAG]     = flag_q;
   end

   always_comb begin
      case (rd_sel)
         SEL_CTRL: rd_data = ctrl_rd;
         SEL_IVAL: rd_data = ival_q;
         SEL_FRAC: rd_data = cnt[0];
         SEL_SEC:  rd_data = cnt[1];
         SEL_MIN:  rd_data = cnt[2];
         SEL_HOUR: rd_data = cnt[3];
         SEL_ICNT: rd_data = icnt;
         default:  rd_data = '0;
      endcase
   end

   assign irq = flag_q;
endmodule

// File: rtl/tic_checker.sv
module tic_checker
   import tic_pkg::*;
#(
   parameter int W      = 8,
   parameter int FRAC_N = 128,
   parameter int SEC_N  = 60,
   parameter int MIN_N  = 60
) (
   input logic         clk,
   input logic         rst_n,
   input logic         wr_en,
   input logic [2:0]   wr_sel,
   input logic         run,
   input logic         adv,
   input logic         ien,
   input logic         flag,
   input logic [W-1:0] icnt,
   input logic [W-1:0] frac,
   input logic [W-1:0] sec,
   input logic [W-1:0] min
);
   assert_frac_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv) && !($past(wr_en) && $past(wr_sel) == SEL_FRAC)) |-> (frac <= W'(FRAC_N - 1)));

   assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sec) < W'(SEC_N - 1) && !($past(wr_en) && $past(wr_sel) == SEL_SEC)) |-> (sec <= W'(SEC_N - 1)));

   assert_min_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(min) < W'(MIN_N - 1) && !($past(wr_en) && $past(wr_sel) == SEL_MIN)) |-> (min <= W'(MIN_N - 1)));

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(run) && !$past(wr_en)) |-> ($stable(frac) && $stable(sec) && $stable(min) && $stable(icnt)));

   assert_icnt_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !ien |-> (icnt == '0));

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(flag) && !($past(wr_en) && $past(wr_sel) == SEL_CTRL)) |-> flag);
endmodule

bind tick_interval_timer tic_checker #(
   .W(CNT_W), .FRAC_N(FRAC_N), .SEC_N(SEC_N), .MIN_N(MIN_N)
) u_tic_checker (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .wr_sel (wr_sel),
   .run    (run_q),
   .adv    (adv),
   .ien    (ien_q),
   .flag   (flag_q),
   .icnt   (icnt),
   .frac   (cnt[0]),
   .sec    (cnt[1]),
   .min    (cnt[2])
);

// File: tb/tb_tick_interval_timer.sv
`timescale 1ns/10ps
module tb_tick_interval_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [2:0] rd_sel = 3'd0;
   logic [7:0] rd_data;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_run, m_ien, m_one, m_unit, m_h24, m_flag;
   int m_ival, m_frac, m_sec, m_min, m_hour, m_icnt;

   always #2.5 clk = ~clk;

   tick_interval_timer dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   task automatic check(input int got, input int exp, input string tag);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic int exp_reg(input int s);
      case (s)
         0: return m_run | (m_ien << 1) | (m_one << 2) | (m_unit << 3) | (m_h24 << 5) | (m_flag << 6);
         1: return m_ival;
         2: return m_frac;
         3: return m_sec;
         4: return m_min;
         5: return m_hour;
         6: return m_icnt;
         default: return 0;
      endcase
   endfunction

   function automatic string reg_tag(input int s);
      case (s)
         0: return "R10 control";
         1: return "R11 interval";
         2: return "R2 fraction";
         3: return "R3 seconds";
         4: return "R3 minutes";
         5: return "R4 hours";
         6: return "R6 interval count";
         default: return "R1 unused";
      endcase
   endfunction

   task automatic read_reg(input int s, output int v);
      rd_sel = 3'(s);
      #0.2;
      v = int'(rd_data);
   endtask

   task automatic compare_all();
      for (int s = 0; s < 8; s++) begin
         int v;
         read_reg(s, v);
         check(v, exp_reg(s), reg_tag(s));
      end
      check(int'(irq), m_flag, "R7 irq");
   endtask

   task automatic model_edge(input bit t, input bit we, input int sel, input int d);
      bit adv, c0, c1, c2, c3, ev, match, cwr;
      int hl;
      adv = t && (m_run != 0);
      c0 = adv && (m_frac >= 127);
      c1 = c0 && (m_sec >= 59);
      c2 = c1 && (m_min >= 59);
      hl = (m_h24 != 0) ? 23 : 255;
      c3 = c2 && (m_hour >= hl);
      case (m_unit)
         0: ev = adv;
         1: ev = c0;
         2: ev = c1;
         default: ev = c2;
      endcase
      match = (m_ien != 0) && ev && (((m_icnt + 1) % 256) == m_ival);
      cwr = we && (sel == 0);
      if (cwr && ((d >> 1) & 1) == 0) m_icnt = 0;
      else if (match) m_icnt = 0;
      else if ((m_ien != 0) && ev) m_icnt = (m_icnt + 1) % 256;
      if (adv) m_frac = c0 ? 0 : m_frac + 1;
      if (c0) m_sec = c1 ? 0 : m_sec + 1;
      if (c1) m_min = c2 ? 0 : m_min + 1;
      if (c2) m_hour = c3 ? 0 : m_hour + 1;
      if (match) begin
         if (m_one != 0) m_ien = 0;
      end
      if (cwr) begin
         m_run  = d & 1;
         m_ien  = (d >> 1) & 1;
         m_one  = (d >> 2) & 1;
         m_unit = (d >> 3) & 3;
         m_h24  = (d >> 5) & 1;
         m_flag = (d >> 6) & 1;
      end
      if (match) begin
         m_flag = 1;
         if (m_one_prev_single(cwr, d)) m_ien = 0;
      end
      if (we && sel == 1) m_ival = d;
      if (we && sel == 2) m_frac = d;
      if (we && sel == 3) m_sec = d;
      if (we && sel == 4) m_min = d;
      if (we && sel == 5) m_hour = d;
   endtask

   // one-shot decision uses the setting held before this edge
   bit one_before;
   function automatic bit m_one_prev_single(input bit cwr, input int d);
      return one_before;
   endfunction

   task automatic step(input bit t, input bit we = 1'b0, input int sel = 0, input int d = 0);
      tick    = t;
      wr_en   = we;
      wr_sel  = 3'(sel);
      wr_data = 8'(d);
      @(posedge clk);
      one_before = (m_one != 0);
      model_edge(t, we, sel, d);
      @(negedge clk);
      tick  = 1'b0;
      wr_en = 1'b0;
      compare_all();
   endtask

   initial begin
      int v;
      m_run = 0; m_ien = 0; m_one = 0; m_unit = 0; m_h24 = 0; m_flag = 0;
      m_ival = 0; m_frac = 0; m_sec = 0; m_min = 0; m_hour = 0; m_icnt = 0;
      one_before = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int s = 0; s < 7; s++) begin
         read_reg(s, v);
         check(v, 0, "R1 reset register");
      end
      check(int'(irq), 0, "R1 reset irq");

      // R2: free running fraction with carries
      step(0, 1, 0, 8'h01);
      for (int i = 0; i < 300; i++) step(1);
      read_reg(3, v);
      check(v, 2, "R2 seconds after 300 ticks");

      // R3/R4: full rollover in day mode
      step(0, 1, 0, 8'h21);
      step(0, 1, 2, 126);
      step(0, 1, 3, 59);
      step(0, 1, 4, 59);
      step(0, 1, 5, 23);
      step(1);
      step(1);
      read_reg(4, v);
      check(v, 0, "R3 minutes wrap");
      read_reg(5, v);
      check(v, 0, "R4 day wrap hours");

      // R4: byte-range hours
      step(0, 1, 0, 8'h01);
      step(0, 1, 5, 23);
      step(0, 1, 2, 127); step(0, 1, 3, 59); step(0, 1, 4, 59);
      step(1);
      read_reg(5, v);
      check(v, 24, "R4 hours pass 23 in byte mode");
      step(0, 1, 5, 255);
      step(0, 1, 2, 127); step(0, 1, 3, 59); step(0, 1, 4, 59);
      step(1);
      read_reg(5, v);
      check(v, 0, "R4 hours wrap from 255");

      // R5: stopped clock ignores ticks
      step(0, 1, 2, 40);
      step(0, 1, 0, 8'h00);
      for (int i = 0; i < 20; i++) step(1);
      read_reg(2, v);
      check(v, 40, "R5 fraction held while stopped");

      // R6/R7: tick unit auto restart
      step(0, 1, 1, 5);
      step(0, 1, 0, 8'h03);
      for (int i = 0; i < 5; i++) step(1);
      check(int'(irq), 1, "R7 irq after five ticks");
      read_reg(6, v);
      check(v, 0, "R7 count restarted");
      for (int i = 0; i < 18; i++) step(1);
      step(0, 1, 0, 8'h03);

      // R6: seconds unit
      step(0, 1, 1, 2);
      step(0, 1, 0, 8'h0B);
      for (int i = 0; i < 600; i++) step(($urandom % 3) != 0);

      // R8: one-shot
      step(0, 1, 0, 8'h01);
      step(0, 1, 1, 3);
      step(0, 1, 0, 8'h07);
      for (int i = 0; i < 10; i++) step(1);
      read_reg(0, v);
      check((v >> 1) & 1, 0, "R8 enable cleared by one-shot");
      read_reg(6, v);
      check(v, 0, "R8 count idle after one-shot");

      // R9: disarm clears count
      step(0, 1, 1, 50);
      step(0, 1, 0, 8'h03);
      for (int i = 0; i < 10; i++) step(1);
      step(1, 1, 0, 8'h01);
      read_reg(6, v);
      check(v, 0, "R9 count cleared on disarm");
      for (int i = 0; i < 5; i++) step(1);

      // R10: match coincides with flag-clearing write
      step(0, 1, 1, 3);
      step(0, 1, 0, 8'h03);
      step(1);
      step(1);
      step(1, 1, 0, 8'h03);
      check(int'(irq), 1, "R10 match wins over clearing write");
      step(0, 1, 0, 8'h03);
      check(int'(irq), 0, "R10 flag cleared by write");

      // R11: preload collides with tick
      step(1, 1, 2, 10);
      read_reg(2, v);
      check(v, 10, "R11 load wins over tick");
      step(0, 1, 2, 127);
      step(1, 1, 3, 7);
      read_reg(3, v);
      check(v, 7, "R11 load wins over carry");

      // random soak
      for (int i = 0; i < 4000; i++) begin
         int r;
         r = int'($urandom % 16);
         if (r == 0) step(($urandom % 2) != 0, 1, int'($urandom % 7), int'($urandom % 256));
         else if (r == 1) step(($urandom % 2) != 0, 1, 0, int'($urandom % 64) | 1);
         else step(($urandom % 4) != 0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule